// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block is a register-mapped serial master that performs one word transfer at a time in one direction only: it either shifts a word of up to 16 bits out to a peripheral or shifts a word of up to 16 bits in from it. There are four chip-select pins. Software picks one of them through a command register. Each select has its own stored setup: the clock edge that moves data out, the clock edge that samples data in, the active level of the select, the serial clock rate, and an optional wait for the peripheral to signal ready on the data-in line. A single bit inverts the idle level of the serial clock for all selects.

Software first loads the outgoing word into the data register, left-aligned so that its top bit goes out first. It then writes one command word. That word holds a go bit, a select-enable bit, the select number and two bit counts: one for sending and one for receiving. Software polls the busy flag. For a receive it also polls the data-valid flag, then reads the received word right-aligned from the data register. The rate divider that produces the base timing lives outside the block and arrives as a one-cycle tick.

Top module: `mw_serial_master`

## Requirements
- R1: After reset the command/status register (index 1) reads 0, every setup register reads 0, all four selects are at their inactive (high) level, the serial clock is low and the data-out line is low.
- R2: Register indices are as follows:
  - 0: writes go to the transmit word; reads return the receive word.
  - 1: command/status.
  - 2: select setup A. Its bits 5:0 hold the 6-bit field for select 0 and its bits 11:6 the field for select 1.
  - 3: select setup B, laid out the same way for selects 2 and 3.
  - 5: bit 0 inverts the clock idle level.
  - 2, 3 and 5: unused bits read 0. All other indices read 0.
- R3: Command bits 9:5 give the send count. When that count is nonzero, exactly that many bits go out, starting at transmit bit 15 and moving downward. A count above 16 acts as 16.
- R4: Command bits 4:0 give the receive count for a command whose send count is zero. The first bit received lands in bit count-1 and the last in bit 0, and the upper bits read 0. Status bit 15 (data valid) is set when the receive ends, in the same cycle that busy falls. Reading index 0 clears it.
- R5: A command written with bit 13 set and a nonzero count raises status bit 14 (busy) on the next cycle. Busy falls after exactly count rising and count falling serial clock edges.
- R6: When both counts are nonzero, only the send runs and data valid stays 0. When both counts are zero, busy never rises and the serial clock does not toggle.
- R7: Any write to index 1 while busy is ignored: the selects, the running transfer and the stored select number are unchanged.
- R8: Command bit 12 asserts the select numbered by bits 11:10, and clearing bit 12 releases it. Changing the number releases the previous select. Field bit 2 set makes that select active high; otherwise it is active low. At most one select is asserted.
- R9: Field bit 1 set makes data-out change on rising edges, so the peripheral samples on falling edges; clear makes it change on falling edges. Field bit 0 set makes the block sample data-in on falling edges; clear makes it sample on rising edges. Edges are those of the non-inverted clock.
- R10: Field bits 4:3 set the serial half period: 00 is one tick, 01 is two ticks, and 10 or 11 is four ticks.
- R11: While idle, the serial clock sits at the value of index 5 bit 0.
- R12: With field bit 5 set, a started transfer stays busy and produces no clock edge while data-in is high. It proceeds once data-in is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick, one cycle wide |
| reg_sel_i | input | 3 | Register word index |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (read side effects) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected index |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in / peripheral ready |
| cs_o | output | 4 | Chip selects, polarity per select |

## Verification
The bench sweeps every select against all four edge-option pairs. It varies the rate code and clock inversion, and runs sends and receives of 1, 7 and 16 bits, modelling the peripheral as one that changes its data on the edge opposite the sample edge. If an edge option is swapped, the captured word comes out shifted by one bit. If the last shift is taken at the closing edge, the final send bit is lost. If the divide decode is wrong, the measured edge spacing changes. Directed cases cover the following:
- A send count of 20, which a design without the 16-bit limit would clock 20 times.
- Commands with both counts set or both zero, which a careless decoder turns into a receive or a zero-length busy pulse.
- A command that intrudes during a long transfer and would re-target the select mid-word.
- The ready hold, which a design ignoring field bit 5 would clock through at once.

// File: rtl/mw_pkg.sv
package mw_pkg;
    localparam int DW  = 16;            // data word width
    localparam int CW  = 5;             // bit-count field width
    localparam int NCS = 4;             // number of chip selects
    localparam int CSW = $clog2(NCS);   // select number width
    localparam int FW  = 6;             // per-select setup field width
    localparam int AW  = 3;             // register index width
    localparam int HW  = CW + 1;        // half-period counter width
    localparam int TW  = 3;             // tick counter width

    localparam logic [AW-1:0] IX_DATA = 3'd0;
    localparam logic [AW-1:0] IX_CTRL = 3'd1;
    localparam logic [AW-1:0] IX_SETA = 3'd2;
    localparam logic [AW-1:0] IX_SETB = 3'd3;
    localparam logic [AW-1:0] IX_IDLE = 3'd5;

    localparam int B_GO   = 13;
    localparam int B_CSON = 12;
    localparam int B_CSLO = 10;
    localparam int B_WLO  = 5;
    localparam int B_RLO  = 0;

    localparam logic [CW-1:0] MAX_BITS = CW'(DW);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RUN
    } eng_st_e;

    // Field layout is decoded by position: bit5 ready check, 4:3 rate,
    // bit2 active-high select, bit1 drive on rising, bit0 sample on falling.
    typedef struct packed {
        logic       rdy_chk;
        logic [1:0] rate;
        logic       cs_high;
        logic       drv_rise;
        logic       smp_fall;
    } sel_cfg_t;
endpackage

// File: rtl/mw_shift_engine.sv
module mw_shift_engine
    import mw_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int CNT_W  = CW
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              is_wr_i,
    input  logic [CNT_W-1:0]  nbits_i,
    input  logic [DATA_W-1:0] tx_i,
    input  sel_cfg_t          cfg_i,
    input  logic              sdi_i,
    output logic              busy_o,
    output logic              is_wr_o,
    output logic              done_rd_o,
    output logic [DATA_W-1:0] rx_o,
    output logic              sclk_lvl_o,
    output logic              sdo_o
);
    localparam int HALF_W = CNT_W + 1;

    typedef struct packed {
        eng_st_e             st;
        logic [HALF_W-1:0]   half;
        logic [TW-1:0]       tcnt;
        logic [TW-1:0]       hlen;
        logic [CNT_W-1:0]    nbits;
        logic                is_wr;
        logic                drv_rise;
        logic                smp_fall;
        logic [DATA_W-1:0]   sh;
    } eng_t;

    eng_t eng_d, eng_q;
    logic done_d;
    logic [HALF_W-1:0] half_nx;
    logic [HALF_W-1:0] half_end;

    always_comb begin
        eng_d    = eng_q;
        done_d   = 1'b0;
        half_nx  = eng_q.half + HALF_W'(1);
        half_end = {eng_q.nbits, 1'b0};
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    eng_d.st       = cfg_i.rdy_chk ? ST_HOLD : ST_RUN;
                    eng_d.half     = '0;
                    eng_d.tcnt     = '0;
                    eng_d.hlen     = (cfg_i.rate == 2'b00) ? TW'(0) :
                                     (cfg_i.rate == 2'b01) ? TW'(1) : TW'(3);
                    eng_d.nbits    = nbits_i;
                    eng_d.is_wr    = is_wr_i;
                    eng_d.drv_rise = cfg_i.drv_rise;
                    eng_d.smp_fall = cfg_i.smp_fall;
                    eng_d.sh       = is_wr_i ? tx_i : '0;
                end
            end
            ST_HOLD: begin
                if (!sdi_i) begin
                    eng_d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (tick_i) begin
                    if (eng_q.tcnt == eng_q.hlen) begin
                        eng_d.tcnt = '0;
                        eng_d.half = half_nx;
                        if (eng_q.is_wr) begin
                            // odd half index = rising edge, even = falling edge
                            if (eng_q.drv_rise ? (half_nx[0] && half_nx != HALF_W'(1))
                                               : (!half_nx[0] && half_nx != half_end)) begin
                                eng_d.sh = {eng_q.sh[DATA_W-2:0], 1'b0};
                            end
                        end else if (eng_q.smp_fall ? !half_nx[0] : half_nx[0]) begin
                            eng_d.sh = {eng_q.sh[DATA_W-2:0], sdi_i};
                        end
                        if (half_nx == half_end) begin
                            eng_d.st = ST_IDLE;
                            done_d   = !eng_q.is_wr;
                        end
                    end else begin
                        eng_d.tcnt = eng_q.tcnt + TW'(1);
                    end
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            eng_q <= '{st: ST_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy_o     = (eng_q.st != ST_IDLE);
    assign is_wr_o    = eng_q.is_wr;
    assign done_rd_o  = done_d;
    assign rx_o       = eng_d.sh;
    assign sclk_lvl_o = (eng_q.st == ST_RUN) && eng_q.half[0];
    assign sdo_o      = eng_q.is_wr & eng_q.sh[DATA_W-1];

    // R5: the half counter never passes the closing edge of the word
    a_r5_half_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_RUN) |-> (eng_q.half < {eng_q.nbits, 1'b0}));

    // R12: a held transfer stays held while data-in is high
    a_r12_hold_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_HOLD && sdi_i) |=> (eng_q.st == ST_HOLD));

    // R10: the tick counter stays within the latched half period
    a_r10_tick_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eng_q.st == ST_RUN) |-> (eng_q.tcnt <= eng_q.hlen));
endmodule

// File: rtl/mw_regs.sv
module mw_regs
    import mw_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [AW-1:0]   sel_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   rdata_o,
    input  logic            busy_i,
    input  logic            rd_done_i,
    input  logic [DW-1:0]   rx_word_i,
    output logic            start_o,
    output logic            start_wr_o,
    output logic [CW-1:0]   start_bits_o,
    output sel_cfg_t        start_cfg_o,
    output logic [DW-1:0]   tx_o,
    output logic            rdy_o,
    output logic            cs_on_o,
    output logic [CSW-1:0]  cs_num_o,
    output logic [NCS-1:0]  pol_o,
    output logic            inv_o
);
    typedef struct packed {
        logic [DW-1:0]    tx;
        logic [DW-1:0]    rx;
        logic             rdy;
        logic             cs_on;
        logic [CSW-1:0]   cs_num;
        logic [CW-1:0]    wcnt;
        logic [CW-1:0]    rcnt;
        logic [2*FW-1:0]  seta;
        logic [2*FW-1:0]  setb;
        logic             inv;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NCS-1:0][FW-1:0] fld;
    logic ctrl_wr;
    logic [CW-1:0] w_cnt, r_cnt, pick_cnt;

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            fld[i] = (i < 2) ? regs_q.seta[(i % 2) * FW +: FW]
                             : regs_q.setb[(i % 2) * FW +: FW];
        end
    end

    always_comb begin
        regs_d   = regs_q;
        ctrl_wr  = wr_i && (sel_i == IX_CTRL) && !busy_i;
        w_cnt    = wdata_i[B_WLO +: CW];
        r_cnt    = wdata_i[B_RLO +: CW];
        pick_cnt = (w_cnt != '0) ? w_cnt : r_cnt;

        start_o      = ctrl_wr && wdata_i[B_GO] && (w_cnt != '0 || r_cnt != '0);
        start_wr_o   = (w_cnt != '0);
        start_bits_o = (pick_cnt > MAX_BITS) ? MAX_BITS : pick_cnt;
        start_cfg_o  = sel_cfg_t'(fld[wdata_i[B_CSLO +: CSW]]);

        if (ctrl_wr) begin
            regs_d.cs_on  = wdata_i[B_CSON];
            regs_d.cs_num = wdata_i[B_CSLO +: CSW];
            regs_d.wcnt   = w_cnt;
            regs_d.rcnt   = r_cnt;
        end
        if (wr_i) begin
            unique case (sel_i)
                IX_DATA: regs_d.tx   = wdata_i;
                IX_SETA: regs_d.seta = wdata_i[2*FW-1:0];
                IX_SETB: regs_d.setb = wdata_i[2*FW-1:0];
                IX_IDLE: regs_d.inv  = wdata_i[0];
                default: ;
            endcase
        end
        if (rd_done_i) begin
            regs_d.rdy = 1'b1;
            regs_d.rx  = rx_word_i;
        end else if (rd_i && sel_i == IX_DATA) begin
            regs_d.rdy = 1'b0;
        end

        unique case (sel_i)
            IX_DATA: rdata_o = regs_q.rx;
            IX_CTRL: rdata_o = {regs_q.rdy, busy_i, 1'b0, regs_q.cs_on,
                                regs_q.cs_num, regs_q.wcnt, regs_q.rcnt};
            IX_SETA: rdata_o = {{(DW-2*FW){1'b0}}, regs_q.seta};
            IX_SETB: rdata_o = {{(DW-2*FW){1'b0}}, regs_q.setb};
            IX_IDLE: rdata_o = {{(DW-1){1'b0}}, regs_q.inv};
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NCS; g++) begin : g_pol
        assign pol_o[g] = fld[g][2];
    end

    assign tx_o     = regs_q.tx;
    assign rdy_o    = regs_q.rdy;
    assign cs_on_o  = regs_q.cs_on;
    assign cs_num_o = regs_q.cs_num;
    assign inv_o    = regs_q.inv;

    // R7: a command write during a transfer leaves the select state alone
    a_r7_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && wr_i && sel_i == IX_CTRL) |=>
            ($stable(regs_q.cs_num) && $stable(regs_q.cs_on)));

    // R4: reading the receive word drops data valid
    a_r4_rdy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && sel_i == IX_DATA && !rd_done_i) |=> !regs_q.rdy);
endmodule

// File: rtl/mw_cs_drive.sv
module mw_cs_drive
    import mw_pkg::*;
#(
    parameter int N_SEL = NCS
) (
    input  logic                     cs_on_i,
    input  logic [$clog2(N_SEL)-1:0] cs_num_i,
    input  logic [N_SEL-1:0]         pol_i,
    output logic [N_SEL-1:0]         cs_o
);
    for (genvar g = 0; g < N_SEL; g++) begin : g_sel
        logic hit;
        assign hit     = cs_on_i && (cs_num_i == ($clog2(N_SEL))'(g));
        assign cs_o[g] = hit ? pol_i[g] : ~pol_i[g];
    end
endmodule

// File: rtl/mw_serial_master.sv
module mw_serial_master
    import mw_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           tick_i,
    input  logic [2:0]     reg_sel_i,
    input  logic           reg_wr_i,
    input  logic           reg_rd_i,
    input  logic [15:0]    reg_wdata_i,
    output logic [15:0]    reg_rdata_o,
    output logic           sclk_o,
    output logic           sdo_o,
    input  logic           sdi_i,
    output logic [3:0]     cs_o
);
    logic            busy, eng_wr, done_rd, sclk_lvl;
    logic            start, start_wr, rdy, cs_on, inv;
    logic [CW-1:0]   start_bits;
    logic [DW-1:0]   tx_word, rx_word;
    logic [CSW-1:0]  cs_num;
    logic [NCS-1:0]  pol;
    sel_cfg_t        start_cfg;

    mw_regs u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sel_i        (reg_sel_i),
        .wr_i         (reg_wr_i),
        .rd_i         (reg_rd_i),
        .wdata_i      (reg_wdata_i),
        .rdata_o      (reg_rdata_o),
        .busy_i       (busy),
        .rd_done_i    (done_rd),
        .rx_word_i    (rx_word),
        .start_o      (start),
        .start_wr_o   (start_wr),
        .start_bits_o (start_bits),
        .start_cfg_o  (start_cfg),
        .tx_o         (tx_word),
        .rdy_o        (rdy),
        .cs_on_o      (cs_on),
        .cs_num_o     (cs_num),
        .pol_o        (pol),
        .inv_o        (inv)
    );

    mw_shift_engine #(.DATA_W(DW), .CNT_W(CW)) u_eng (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .start_i    (start),
        .is_wr_i    (start_wr),
        .nbits_i    (start_bits),
        .tx_i       (tx_word),
        .cfg_i      (start_cfg),
        .sdi_i      (sdi_i),
        .busy_o     (busy),
        .is_wr_o    (eng_wr),
        .done_rd_o  (done_rd),
        .rx_o       (rx_word),
        .sclk_lvl_o (sclk_lvl),
        .sdo_o      (sdo_o)
    );

    mw_cs_drive #(.N_SEL(NCS)) u_cs (
        .cs_on_i  (cs_on),
        .cs_num_i (cs_num),
        .pol_i    (pol),
        .cs_o     (cs_o)
    );

    assign sclk_o = sclk_lvl ^ inv;

    // R5: an accepted go command with a nonzero count makes the block busy
    a_r5_busy_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_sel_i == IX_CTRL && reg_wdata_i[B_GO] &&
         reg_wdata_i[9:0] != 10'd0 && !busy) |=> busy);

    // R6: a go command with both counts zero never starts anything
    a_r6_zero_counts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_sel_i == IX_CTRL && reg_wdata_i[9:0] == 10'd0 && !busy)
            |=> !busy);

    // R4: a finished receive leaves data valid set
    a_r4_rdy_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(busy) && !eng_wr) |-> rdy);

    // R11: the serial clock rests at the programmed idle level
    a_r11_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy |-> (sclk_o == inv));

    // R8: never more than one select at its active level
    a_r8_single_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~(cs_o ^ pol)));
endmodule

// File: tb/mw_serial_master_tb.sv
module mw_serial_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [2:0]  sel = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        sclk, sdo;
    logic        sdi;
    logic [3:0]  cs;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    int cyc = 0, tcount = 0, tick_per = 1;

    // peripheral model state
    bit          mon_en = 0, mon_inv = 0, mon_rd = 0, mon_drv_rise = 0, mon_smp_fall = 0;
    bit          hold_hi = 0, prev_lvl = 0;
    int          mon_n = 0, nrise = 0, nfall = 0, scnt = 0, last_edge = -1;
    int          gap_exp = 1, gap_bad = 0, cs_bad = 0;
    logic [15:0] mon_pat = '0, cap = '0;
    logic [3:0]  cs_exp = 4'hF;
    logic [11:0] sha = '0, shb = '0;

    mw_serial_master dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
        .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .sclk_o(sclk), .sdo_o(sdo), .sdi_i(sdi), .cs_o(cs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sdi = hold_hi | (mon_rd && scnt < mon_n && mon_pat[mon_n - 1 - scnt]);

    always @(negedge clk) begin
        tcount++;
        tick = ((tcount % tick_per) == 0);
    end

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if ((sclk ^ mon_inv) != prev_lvl) begin
                bit lvl;
                lvl = sclk ^ mon_inv;
                if (last_edge >= 0 && (cyc - last_edge) != gap_exp) gap_bad++;
                last_edge = cyc;
                if (cs !== cs_exp) cs_bad++;
                if (lvl) nrise++; else nfall++;
                if (!mon_rd) begin
                    if (lvl == !mon_drv_rise) cap = {cap[14:0], sdo};
                end else if (lvl == !mon_smp_fall) begin
                    scnt++;
                end
                prev_lvl = lvl;
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > WATCHDOG && !finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int idx, input logic [15:0] d);
        @(negedge clk);
        sel = 3'(idx); wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input int idx, output logic [15:0] v);
        @(negedge clk);
        sel = 3'(idx); rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    function automatic bit pol_of(input int i);
        logic [11:0] s;
        s = (i < 2) ? sha : shb;
        return s[(i % 2) * 6 + 2];
    endfunction

    function automatic logic [3:0] cs_vec(input bit on, input int num);
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = (on && i == num) ? pol_of(i) : ~pol_of(i);
        return v;
    endfunction

    task automatic arm_monitor(input bit inv, input bit is_rd, input logic [5:0] cfg,
                               input int n, input logic [15:0] pat, input logic [3:0] csv);
        int hl;
        hl = (cfg[4:3] == 2'b00) ? 1 : (cfg[4:3] == 2'b01) ? 2 : 4;
        mon_inv = inv; mon_rd = is_rd; mon_drv_rise = cfg[1]; mon_smp_fall = cfg[0];
        mon_n = n; mon_pat = pat; nrise = 0; nfall = 0; scnt = 0; cap = '0;
        prev_lvl = 0; last_edge = -1; gap_exp = hl * tick_per; gap_bad = 0; cs_bad = 0;
        cs_exp = csv; mon_en = 1;
    endtask

    task automatic xfer(input int csn, input bit is_rd, input int n_cmd, input int extra_rd,
                        input logic [15:0] data, input logic [5:0] cfg, input bit inv,
                        input bit intrude, input bit hold);
        logic [15:0] v, r, ctrl;
        int n, mask;
        if (csn < 2) begin sha[(csn % 2) * 6 +: 6] = cfg; wreg(2, {4'h0, sha}); end
        else         begin shb[(csn % 2) * 6 +: 6] = cfg; wreg(3, {4'h0, shb}); end
        wreg(5, {15'h0, inv});
        if (!is_rd) wreg(0, data);
        n = (n_cmd > 16) ? 16 : n_cmd;
        mask = (1 << n) - 1;
        arm_monitor(inv, is_rd, cfg, n, data, cs_vec(1, csn));
        ctrl = 16'h3000 | 16'(csn << 10) |
               (is_rd ? 16'(n_cmd) : (16'(n_cmd << 5) | 16'(extra_rd)));
        if (hold) hold_hi = 1;
        wreg(1, ctrl);
        rreg(1, v);
        check(v[14] == 1'b1, "R5 busy after go", v[14], 1);
        if (hold) begin
            repeat (30) @(negedge clk);
            rreg(1, v);
            check(v[14] == 1'b1 && (nrise + nfall) == 0, "R12 held while data-in high",
                  nrise + nfall, 0);
            hold_hi = 0;
        end
        if (intrude) begin
            wreg(1, 16'h2003 | 16'(((csn + 1) % 4) << 10));
            rreg(1, v);
            check(v[11:10] == 2'(csn) && v[12] == 1'b1, "R7 command ignored while busy",
                  v[12:10], 3'(4 + csn));
        end
        for (int k = 0; k < 3000; k++) begin
            rreg(1, v);
            if (!v[14]) break;
        end
        mon_en = 0;
        check(nrise == n && nfall == n, "R5 edge count", nrise * 256 + nfall, n * 256 + n);
        check(gap_bad == 0, "R10 half period spacing", gap_bad, 0);
        check(cs_bad == 0, "R8 select level during transfer", cs_bad, 0);
        check(sclk == inv, "R11 idle clock level", sclk, inv);
        if (!is_rd) begin
            check((cap & 16'(mask)) == (data >> (16 - n)), "R3 R9 sent word",
                  cap & 16'(mask), data >> (16 - n));
            if (extra_rd != 0)
                check(v[15] == 1'b0, "R6 receive count ignored", v[15], 0);
        end else begin
            check(v[15] == 1'b1, "R4 data valid at end", v[15], 1);
            rreg(0, r);
            check(r == (data & 16'(mask)), "R4 R9 received word", r, data & 16'(mask));
            rreg(1, v);
            check(v[15] == 1'b0, "R4 valid cleared by read", v[15], 0);
        end
    endtask

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cs == 4'hF && sclk == 1'b0 && sdo == 1'b0, "R1 pins after reset",
              {cs, sclk, sdo}, 6'b111100);
        rreg(1, v); check(v == 16'h0, "R1 status after reset", v, 0);
        rreg(2, v); check(v == 16'h0, "R1 setup after reset", v, 0);

        // R2 register map
        wreg(2, 16'hFFFF); rreg(2, v); check(v == 16'h0FFF, "R2 setup A width", v, 16'h0FFF);
        wreg(2, 16'h0000);
        wreg(6, 16'hFFFF); rreg(6, v); check(v == 16'h0, "R2 unused index", v, 0);
        wreg(5, 16'hFFFF); rreg(5, v); check(v == 16'h1, "R2 idle register", v, 1);
        check(sclk == 1'b1, "R11 inverted idle", sclk, 1);
        wreg(5, 16'h0);
        wreg(0, 16'hBEEF); rreg(0, v); check(v == 16'h0, "R2 index 0 reads receive", v, 0);

        // R8 select handling without transfer
        shb = 12'h104;  // select 2 and 3 active high
        wreg(3, {4'h0, shb});
        wreg(1, 16'h1000 | 16'(2 << 10)); @(negedge clk);
        check(cs == cs_vec(1, 2), "R8 assert select 2", cs, cs_vec(1, 2));
        wreg(1, 16'h1000 | 16'(3 << 10)); @(negedge clk);
        check(cs == cs_vec(1, 3), "R8 move to select 3", cs, cs_vec(1, 3));
        wreg(1, 16'(3 << 10)); @(negedge clk);
        check(cs == cs_vec(0, 0), "R8 release", cs, cs_vec(0, 0));

        // R6 both counts zero
        arm_monitor(0, 0, 6'h0, 0, 16'h0, cs_vec(1, 0));
        wreg(1, 16'h3000);
        rreg(1, v); check(v[14] == 1'b0, "R6 zero counts no busy", v[14], 0);
        repeat (20) @(negedge clk);
        mon_en = 0;
        check(nrise + nfall == 0, "R6 zero counts no clock", nrise + nfall, 0);

        // sweep: selects x edge options, rates and inversion derived arithmetically
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 4; m++) begin
                logic [5:0] cfg;
                int lens[3];
                lens = '{1, 7, 16};
                cfg = {1'b0, 2'((c + m) % 3), 1'(c % 2), 1'(m / 2), 1'(m % 2)};
                tick_per = (c == 3) ? 2 : 1;
                for (int l = 0; l < 3; l++) begin
                    logic [15:0] d;
                    d = 16'((c * 4 + m) * 16'h1D37 + lens[l] * 16'h0F0B) ^ 16'h5AA5;
                    xfer(c, 0, lens[l], 0, d, cfg, 1'((m % 2) ^ (c / 2)), 0, 0);
                    xfer(c, 1, lens[l], 0, ~d, cfg, 1'((m / 2) ^ (c % 2)), 0, 0);
                end
            end
        end
        tick_per = 1;

        // R3 count above 16 saturates
        xfer(0, 0, 20, 0, 16'hC3A5, 6'b000000, 0, 0, 0);
        // R6 both counts set: send only
        xfer(1, 0, 4, 6, 16'h9000, 6'b000010, 0, 0, 0);
        // R7 intruding command during a slow 16-bit send
        xfer(1, 0, 16, 0, 16'h6E1B, 6'b010001, 1, 1, 0);
        // R12 ready hold
        xfer(0, 0, 6, 0, 16'hB400, 6'b100000, 0, 0, 1);

        summary();
    end
endmodule